// File: doc/BRIEF.md
# Satellite channel-router command decoder

This block sits behind a tone-bus receiver that has already turned the line signal into bytes. It takes the bytes of one received command frame, one per strobe, along with a marker for the end of the frame. It checks that the frame has exactly five bytes: a framing byte, a slave address, a command and two data bytes. It also checks that the framing and command values are among the accepted ones. From the data bytes it extracts the channel-router index, the RF feed and a 10-bit tuning word.

A valid frame produces one dispatch record for the serial-bus master downstream. The record holds the bus line to use and the device address of the selected router. It also holds the tuning word, the feed, the passed-through slave byte, and flags for channel change, power-off and installation mode. When the framing byte asks for a reply, the block separately raises a one-cycle request for a fixed response byte.

The record is held until the downstream side takes it. While the record is held, the block ignores all incoming traffic.

Top module: `satcr_cmd_decoder`

## Requirements
- R1: A synchronous active-high reset clears `dispValid` and `respValid` and returns the byte count to the start of a frame. Bytes received before the reset do not count toward the next frame.
- R2: A frame dispatches when it has exactly five bytes, an accepted framing byte and an accepted command. `dispValid` rises in the cycle after the cycle that carries `frameEnd`. The router index is data byte 1 bits 7:5. The feed is data byte 1 bits 4:2. The tuning word is {data byte 1 bits 1:0, data byte 2}.
- R3: The framing byte must be E0h or E2h. With any other framing byte, the frame gives neither a dispatch nor a response request.
- R4: The command byte must be 5Ah or 5Bh. With any other command byte, the frame gives no dispatch.
- R5: A tuning word of zero sets `dispPowerOff`=1 and `dispChange`=0. Any nonzero tuning word sets `dispChange`=1 and `dispPowerOff`=0.
- R6: `dispInstall` is 1 when the command byte is 5Bh and 0 when it is 5Ah.
- R7: A five-byte frame with framing byte E2h raises `respValid` for exactly one cycle, with `respByte`=E4h, in the cycle after the end marker. This holds whatever the command byte is. Framing byte E0h raises no request.
- R8: `dispBusLine` is the router index divided by two, so code 0 to 3 selects bus line 1 to 4. `dispDevAddr` is C8h for an even router index and CAh for an odd one.
- R9: A frame of fewer or more than five bytes gives neither a dispatch nor a response request.
- R10: `dispValid` and every record field hold steady until a cycle with `dispReady`=1. `dispValid` then falls on the next edge. Bytes and end markers that arrive while `dispValid` is high are ignored.
- R11: The second byte of the frame appears unchanged on `dispSlave`.
- R12: A byte presented in the same cycle as `frameEnd` counts as the last byte of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | `byteData` holds a received byte |
| byteData | input | 8 | Received frame byte |
| frameEnd | input | 1 | End-of-frame marker |
| dispReady | input | 1 | Downstream takes the pending record |
| dispValid | output | 1 | Dispatch record pending |
| dispBusLine | output | 2 | Bus line code, 0..3 = line 1..4 |
| dispDevAddr | output | 8 | Device address of the selected router |
| dispSlave | output | 8 | Slave address byte of the frame |
| dispRouter | output | 3 | Router index |
| dispFeed | output | 3 | RF feed number |
| dispTune | output | 10 | Tuning word |
| dispChange | output | 1 | Channel-change request |
| dispPowerOff | output | 1 | Power-off request |
| dispInstall | output | 1 | Installation-mode command |
| respValid | output | 1 | One-cycle request to send a response byte |
| respByte | output | 8 | Response byte value |

## Verification
A byte counter that is off by one shifts every field of the record by one byte. The next frame then shows a wrong router, slave or tuning word, or no dispatch at all, in the cycle after its end marker. A counter that does not saturate or does not clear can make a six-byte frame look like a valid one, or spoil the frame that follows a reset. A broken hold condition shows in one of two ways. Either `dispValid` drops before `dispReady` arrives, or the fields change under a pending record when a second frame is pushed in. Both are visible on the first cycle of the pending window.

// File: rtl/satcr_pkg.sv
package satcr_pkg;
  localparam int BYTE_W    = 8;
  localparam int FRAME_LEN = 5;
  localparam int OVER_CNT  = FRAME_LEN + 1;
  localparam int CNT_W     = $clog2(OVER_CNT + 1);
  localparam int IDX_W     = 3;
  localparam int LINE_W    = IDX_W - 1;
  localparam int TUNE_HI_W = 2;
  localparam int TUNE_W    = BYTE_W + TUNE_HI_W;

  // byte positions inside a frame
  localparam int POS_FRAMING = 0;
  localparam int POS_SLAVE   = 1;
  localparam int POS_CMD     = 2;
  localparam int POS_DATA1   = 3;
  localparam int POS_DATA2   = 4;

  localparam logic [BYTE_W-1:0] FRAMING_PLAIN = 8'hE0;
  localparam logic [BYTE_W-1:0] FRAMING_REPLY = 8'hE2;
  localparam logic [BYTE_W-1:0] CMD_OPERATE   = 8'h5A;
  localparam logic [BYTE_W-1:0] CMD_INSTALL   = 8'h5B;

  // control to datapath strobes
  typedef struct packed {
    logic [FRAME_LEN-1:0] capByte;
    logic                 frameDone;
  } ctrlStrobes_t;
endpackage

// File: rtl/satcr_ctrl.sv
module satcr_ctrl
  import satcr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         byteValid,
  input  logic         frameEnd,
  input  logic         dispReady,
  input  logic         hdrOk,
  input  logic         cmdOk,
  input  logic         replyReq,
  output ctrlStrobes_t strobes,
  output logic         dispValid,
  output logic         respValid
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntInc;
  logic [CNT_W-1:0] endCount;
  logic             accept;
  logic             fullFrame;

  assign accept = !dispValid;

  always_comb begin
    cntInc   = (cnt == CNT_W'(OVER_CNT)) ? cnt : cnt + 1'b1;
    endCount = byteValid ? cntInc : cnt;
  end

  generate
    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_cap
      assign strobes.capByte[i] = accept && byteValid && (cnt == CNT_W'(i));
    end
  endgenerate

  assign fullFrame         = accept && frameEnd && (endCount == CNT_W'(FRAME_LEN));
  assign strobes.frameDone = fullFrame;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      dispValid <= 1'b0;
      respValid <= 1'b0;
    end else begin
      respValid <= fullFrame && hdrOk && replyReq;
      if (dispValid && dispReady)
        dispValid <= 1'b0;
      else if (fullFrame && hdrOk && cmdOk)
        dispValid <= 1'b1;
      if (accept) begin
        if (frameEnd)
          cnt <= '0;
        else if (byteValid)
          cnt <= cntInc;
      end
    end
  end
endmodule

// File: rtl/satcr_datapath.sv
module satcr_datapath
  import satcr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_EVEN = 8'hC8,
  parameter logic [BYTE_W-1:0] ADDR_ODD  = 8'hCA,
  parameter logic [BYTE_W-1:0] RESP_CODE = 8'hE4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byteData,
  input  ctrlStrobes_t      strobes,
  output logic              hdrOk,
  output logic              cmdOk,
  output logic              replyReq,
  output logic [LINE_W-1:0] dispBusLine,
  output logic [BYTE_W-1:0] dispDevAddr,
  output logic [BYTE_W-1:0] dispSlave,
  output logic [IDX_W-1:0]  dispRouter,
  output logic [IDX_W-1:0]  dispFeed,
  output logic [TUNE_W-1:0] dispTune,
  output logic              dispChange,
  output logic              dispPowerOff,
  output logic              dispInstall,
  output logic [BYTE_W-1:0] respByte
);
  logic [BYTE_W-1:0] frameBytes [FRAME_LEN];

  generate
    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_store
      always_ff @(posedge clk) begin
        if (rst)
          frameBytes[i] <= '0;
        else if (strobes.capByte[i])
          frameBytes[i] <= byteData;
      end
    end
  endgenerate

  logic [BYTE_W-1:0] framing, cmd, data1, data2;
  assign framing = frameBytes[POS_FRAMING];
  assign cmd     = frameBytes[POS_CMD];
  assign data1   = frameBytes[POS_DATA1];
  assign data2   = frameBytes[POS_DATA2];

  assign hdrOk    = (framing == FRAMING_PLAIN) || (framing == FRAMING_REPLY);
  assign replyReq = (framing == FRAMING_REPLY);
  assign cmdOk    = (cmd == CMD_OPERATE) || (cmd == CMD_INSTALL);

  always_comb begin
    dispRouter   = data1[BYTE_W-1 -: IDX_W];
    dispFeed     = data1[TUNE_HI_W +: IDX_W];
    dispTune     = {data1[TUNE_HI_W-1:0], data2};
    dispBusLine  = dispRouter[IDX_W-1:1];
    dispDevAddr  = dispRouter[0] ? ADDR_ODD : ADDR_EVEN;
    dispSlave    = frameBytes[POS_SLAVE];
    dispPowerOff = (dispTune == '0);
    dispChange   = !dispPowerOff;
    dispInstall  = (cmd == CMD_INSTALL);
    respByte     = RESP_CODE;
  end
endmodule

// File: rtl/satcr_cmd_decoder.sv
module satcr_cmd_decoder
  import satcr_pkg::*;
#(
  parameter logic [7:0] ADDR_EVEN = 8'hC8,
  parameter logic [7:0] ADDR_ODD  = 8'hCA,
  parameter logic [7:0] RESP_CODE = 8'hE4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       frameEnd,
  input  logic       dispReady,
  output logic       dispValid,
  output logic [1:0] dispBusLine,
  output logic [7:0] dispDevAddr,
  output logic [7:0] dispSlave,
  output logic [2:0] dispRouter,
  output logic [2:0] dispFeed,
  output logic [9:0] dispTune,
  output logic       dispChange,
  output logic       dispPowerOff,
  output logic       dispInstall,
  output logic       respValid,
  output logic [7:0] respByte
);
  ctrlStrobes_t strobes;
  logic hdrOk, cmdOk, replyReq;

  satcr_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .byteValid (byteValid),
    .frameEnd  (frameEnd),
    .dispReady (dispReady),
    .hdrOk     (hdrOk),
    .cmdOk     (cmdOk),
    .replyReq  (replyReq),
    .strobes   (strobes),
    .dispValid (dispValid),
    .respValid (respValid)
  );

  satcr_datapath #(
    .ADDR_EVEN (ADDR_EVEN),
    .ADDR_ODD  (ADDR_ODD),
    .RESP_CODE (RESP_CODE)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .byteData     (byteData),
    .strobes      (strobes),
    .hdrOk        (hdrOk),
    .cmdOk        (cmdOk),
    .replyReq     (replyReq),
    .dispBusLine  (dispBusLine),
    .dispDevAddr  (dispDevAddr),
    .dispSlave    (dispSlave),
    .dispRouter   (dispRouter),
    .dispFeed     (dispFeed),
    .dispTune     (dispTune),
    .dispChange   (dispChange),
    .dispPowerOff (dispPowerOff),
    .dispInstall  (dispInstall),
    .respByte     (respByte)
  );
endmodule

// File: rtl/satcr_cmd_decoder_chk.sv
module satcr_cmd_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       frameEnd,
  input logic       dispReady,
  input logic       dispValid,
  input logic [1:0] dispBusLine,
  input logic [7:0] dispDevAddr,
  input logic [7:0] dispSlave,
  input logic [2:0] dispRouter,
  input logic [2:0] dispFeed,
  input logic [9:0] dispTune,
  input logic       dispChange,
  input logic       dispPowerOff,
  input logic       dispInstall,
  input logic       respValid
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!dispValid && !respValid));

  p_disp_after_end_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dispValid) |-> $past(frameEnd));

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    dispValid |-> $onehot({dispChange, dispPowerOff}));

  p_resp_after_end_r9: assert property (@(posedge clk) disable iff (rst)
    respValid |-> $past(frameEnd));

  p_resp_single_r7: assert property (@(posedge clk) disable iff (rst)
    respValid |=> !respValid);

  p_hold_record_r10: assert property (@(posedge clk) disable iff (rst)
    (dispValid && !dispReady) |=> (dispValid && $stable(dispTune) &&
      $stable(dispRouter) && $stable(dispFeed) && $stable(dispSlave) &&
      $stable(dispBusLine) && $stable(dispDevAddr) && $stable(dispInstall)));

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    (dispValid && dispReady) |=> !dispValid);
endmodule

bind satcr_cmd_decoder satcr_cmd_decoder_chk u_chk (.*);

// File: tb/tb_satcr_cmd_decoder.sv
module tb_satcr_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       frameEnd = 1'b0;
  logic       dispReady = 1'b0;
  logic       dispValid;
  logic [1:0] dispBusLine;
  logic [7:0] dispDevAddr;
  logic [7:0] dispSlave;
  logic [2:0] dispRouter;
  logic [2:0] dispFeed;
  logic [9:0] dispTune;
  logic       dispChange, dispPowerOff, dispInstall;
  logic       respValid;
  logic [7:0] respByte;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  satcr_cmd_decoder dut (.*);

  typedef struct packed {
    logic [7:0] fr, sl, cm, d1, d2;
    logic       expD, expR;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'hE0, 8'h10, 8'h5A, 8'h04, 8'h55, 1'b1, 1'b0}, // router0 feed1
    '{8'hE2, 8'h11, 8'h5A, 8'h3F, 8'hFF, 1'b1, 1'b1}, // router1 feed7 tune 3FF
    '{8'hE0, 8'h12, 8'h5B, 8'hA8, 8'h00, 1'b1, 1'b0}, // router5 power-off install
    '{8'hE2, 8'h13, 8'h5B, 8'hE1, 8'h00, 1'b1, 1'b1}, // router7 tune 100h
    '{8'hE1, 8'h14, 8'h5A, 8'h20, 8'h01, 1'b0, 1'b0}, // bad framing
    '{8'hE2, 8'h15, 8'h5C, 8'h20, 8'h01, 1'b0, 1'b1}, // bad cmd, reply
    '{8'hE0, 8'h16, 8'h00, 8'h20, 8'h01, 1'b0, 1'b0}, // bad cmd
    '{8'hE0, 8'h17, 8'h5A, 8'h4E, 8'h80, 1'b1, 1'b0}, // router2
    '{8'hE0, 8'h18, 8'h5A, 8'h60, 8'h02, 1'b1, 1'b0}, // router3
    '{8'hE0, 8'h19, 8'h5A, 8'h80, 8'h03, 1'b1, 1'b0}, // router4
    '{8'hE0, 8'h1A, 8'h5A, 8'hC0, 8'h01, 1'b1, 1'b0}, // router6
    '{8'hA2, 8'h1B, 8'h5B, 8'hC0, 8'h01, 1'b0, 1'b0}  // bad framing
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bytes packed low byte first; returns at the negedge after the end edge
  task automatic sendFrame(input logic [63:0] bytes, input int n, input bit endOnLast);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = bytes[8*i +: 8];
      frameEnd  = endOnLast && (i == n - 1);
    end
    if (!endOnLast || n == 0) begin
      @(negedge clk);
      byteValid = 1'b0;
      frameEnd  = 1'b1;
    end
    @(negedge clk);
    byteValid = 1'b0;
    frameEnd  = 1'b0;
  endtask

  task automatic release1();
    dispReady = 1'b1;
    @(negedge clk);
    dispReady = 1'b0;
  endtask

  task automatic checkRecord(input vec_t v, input string tag);
    logic [2:0] r;
    logic [9:0] t;
    r = v.d1[7:5];
    t = {v.d1[1:0], v.d2};
    chk(dispRouter == r, {tag, " R2 router"}, dispRouter, r);
    chk(dispFeed == v.d1[4:2], {tag, " R2 feed"}, dispFeed, v.d1[4:2]);
    chk(dispTune == t, {tag, " R2 tune"}, dispTune, t);
    chk(dispPowerOff == (t == 0), {tag, " R5 poweroff"}, dispPowerOff, t == 0);
    chk(dispChange == (t != 0), {tag, " R5 change"}, dispChange, t != 0);
    chk(dispInstall == (v.cm == 8'h5B), {tag, " R6 install"}, dispInstall, v.cm == 8'h5B);
    chk(dispBusLine == r[2:1], {tag, " R8 line"}, dispBusLine, r[2:1]);
    chk(dispDevAddr == (r[0] ? 8'hCA : 8'hC8), {tag, " R8 addr"}, dispDevAddr, r[0] ? 8'hCA : 8'hC8);
    chk(dispSlave == v.sl, {tag, " R11 slave"}, dispSlave, v.sl);
  endtask

  function automatic logic [63:0] pack(input vec_t v);
    return {24'h0, v.d2, v.d1, v.cm, v.sl, v.fr};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(dispValid == 0, "R1 reset dispValid", dispValid, 0);
    chk(respValid == 0, "R1 reset respValid", respValid, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      sendFrame(pack(v), 5, 1'b0);
      chk(dispValid == v.expD, "R2 R3 R4 dispatch", dispValid, v.expD);
      chk(respValid == v.expR, "R7 R3 response", respValid, v.expR);
      if (v.expR) chk(respByte == 8'hE4, "R7 respByte", respByte, 8'hE4);
      if (v.expD) checkRecord(v, "vec");
      @(negedge clk);
      chk(respValid == 0, "R7 single pulse", respValid, 0);
      chk(dispValid == v.expD, "R10 held without ready", dispValid, v.expD);
      if (v.expD) begin
        checkRecord(v, "hold R10");
        release1();
        chk(dispValid == 0, "R10 released", dispValid, 0);
      end
    end

    // R9: short frame with reply framing
    sendFrame(64'h0000_0001_045A_10E2, 4, 1'b0);
    chk(dispValid == 0, "R9 short disp", dispValid, 0);
    chk(respValid == 0, "R9 short resp", respValid, 0);
    // R9: six-byte frame
    sendFrame(64'h0000_7701_045A_10E2, 6, 1'b0);
    chk(dispValid == 0, "R9 long disp", dispValid, 0);
    chk(respValid == 0, "R9 long resp", respValid, 0);

    // R12: end marker with last byte
    begin
      vec_t v;
      v = '{8'hE2, 8'h21, 8'h5A, 8'h6D, 8'h42, 1'b1, 1'b1};
      sendFrame(pack(v), 5, 1'b1);
      chk(dispValid == 1, "R12 same-cycle end", dispValid, 1);
      chk(respValid == 1, "R12 response", respValid, 1);
      checkRecord(v, "R12");
      // R10: another frame while pending is ignored
      sendFrame(64'h0000_00FF_E05B_33E2, 5, 1'b0);
      chk(dispValid == 1, "R10 still pending", dispValid, 1);
      chk(respValid == 0, "R10 no resp while busy", respValid, 0);
      checkRecord(v, "busy R10");
      release1();
      chk(dispValid == 0, "R10 released", dispValid, 0);
      @(negedge clk);
      chk(dispValid == 0, "R10 ignored frame no dispatch", dispValid, 0);
      // next good frame decodes normally after busy window
      v = '{8'hE0, 8'h22, 8'h5A, 8'h9C, 8'h07, 1'b1, 1'b0};
      sendFrame(pack(v), 5, 1'b0);
      chk(dispValid == 1, "R10 after busy", dispValid, 1);
      checkRecord(v, "after busy R10");
      release1();
    end

    // R1: reset mid-frame discards earlier bytes
    sendFrame(64'h0000_0000_005A_10E0, 3, 1'b0);
    @(negedge clk); // nothing
    byteValid = 1'b1; byteData = 8'hE0;
    @(negedge clk); byteData = 8'h10;
    @(negedge clk); byteData = 8'h5A;
    @(negedge clk); byteValid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    sendFrame(64'h0000_0000_0000_0104, 2, 1'b0);
    chk(dispValid == 0, "R1 reset mid-frame", dispValid, 0);
    // R1: reset clears pending dispatch
    sendFrame(64'h0000_0001_045A_10E2, 5, 1'b0);
    chk(dispValid == 1, "R1 pre-reset dispatch", dispValid, 1);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(dispValid == 0, "R1 reset clears dispatch", dispValid, 0);
    chk(respValid == 0, "R1 reset clears resp", respValid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule